// File: doc/BRIEF.md
# Framing Overhead Extraction Port

This block takes the framing overhead bits found by a DS3 or E3 receive framer and sends them out on a slow serial port, so that external logic can watch them. The framer core gives a strobe for each overhead slot, the slot index and the slot contents. In both T3 sub-modes and in G.751 mode a slot holds one bit (data bit 0). In G.832 mode a slot holds one whole overhead byte. The block puts each accepted slot into a small elastic buffer. A serializer then drains the buffer and makes one output clock pulse for each overhead bit. The output data and the start-of-sequence marker change on the falling edge of that clock, so external logic samples them on the rising edge.

The serializer is a three-state machine. In `SER_IDLE` the clock is low and nothing is pending. In `SER_LOW` the clock is low for HALF_CYC cycles and the data is presented. In `SER_HIGH` the clock is high for HALF_CYC cycles and the data is sampled. The transitions are:
- `start` (IDLE→LOW): the buffer holds an entry, which is popped.
- `rise` (LOW→HIGH): the low half has ended.
- `next_bit` (HIGH→LOW): more bits of the current slot remain.
- `next_slot` (HIGH→LOW with pop): the slot is finished and another entry is waiting.
- `drain` (HIGH→IDLE): the slot is finished and the buffer is empty.

While the framer reports loss of frame, no new slots are accepted and the data and marker outputs are forced inactive. The clock, data and marker outputs each have their own polarity inversion.

Top module: `ohx_port`

## Requirements
- R1: After reset, with all inversions off, the overhead clock, data and marker outputs are 0 and the overflow flag is 0.
- R2: In modes 0, 1 and 2 (0 = T3 C-bit, 1 = T3 M23, 2 = E3 G.751), each accepted slot produces exactly one overhead clock pulse. That pulse carries data bit 0 of the slot, and the data does not change while the clock is high.
- R3: In mode 3 (E3 G.832), each accepted slot produces eight clock pulses that carry the slot byte, most significant bit first.
- R4: The marker is 1 only during the bit period of the first bit of a slot whose index is 0. It is 0 for every other bit.
- R5: In mode 1 (T3 M23), slots that carry C-bits are exported exactly as they are in mode 0. No slot is suppressed.
- R6: The clock stays low when no bit is pending. When a strobe reaches an idle block at clock edge t, the first rising edge of the overhead clock comes at edge t+1+HALF_CYC. Each bit then lasts 2*HALF_CYC cycles.
- R7: The buffer holds DEPTH slots. A strobe that arrives while the buffer is full and not being popped is dropped. The overflow flag then goes to 1 and stays at 1 until reset.
- R8: While loss of frame is high, strobes are ignored and produce no clock pulse. From the next cycle on, the data and marker outputs show their inactive level.
- R9: Each of the clock, data and marker outputs is inverted when its own inversion input is 1, and each inversion is independent of the other two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fr_mode | input | 2 | Framing mode: 0 T3 C-bit, 1 T3 M23, 2 E3 G.751, 3 E3 G.832 |
| fr_lof | input | 1 | Loss of frame reported by the framer |
| fr_oh_stb | input | 1 | Overhead slot strobe, one cycle per slot |
| fr_oh_idx | input | IDX_W | Slot index within the frame; 0 marks the first slot |
| fr_oh_data | input | 8 | Slot contents (bit 0 in bit modes, a full byte in G.832 mode) |
| cfg_inv_clk | input | 1 | Invert the overhead clock output |
| cfg_inv_dat | input | 1 | Invert the overhead data output |
| cfg_inv_sof | input | 1 | Invert the start marker output |
| oh_clk | output | 1 | Low-rate overhead clock |
| oh_dat | output | 1 | Serial overhead data |
| oh_sof | output | 1 | Start-of-sequence marker |
| oh_ovf | output | 1 | Sticky elastic-buffer overflow flag |

## Verification
A slot strobed into an idle block at edge t gives its first rising clock edge at edge t+1+HALF_CYC. Each following bit rises 2*HALF_CYC cycles after the one before it. The loss-of-frame gating and the overflow flag take effect one edge after the cause. The bench drives inputs on the falling core-clock edge and samples outputs on the falling edge. It finds overhead clock rises by comparing successive samples, matches each rise in order against a queue of expected bits and marker values, and compares the cycle stamp of the first rise with t+1+HALF_CYC. Level checks are made only after the buffer has drained plus a full bit period, or one or two cycles after a control input changes, so each result has already settled when it is sampled.

// File: rtl/ohx_pkg.sv
package ohx_pkg;

    typedef enum logic [1:0] {
        MODE_T3_CBIT = 2'd0,
        MODE_T3_M23  = 2'd1,
        MODE_E3_G751 = 2'd2,
        MODE_E3_G832 = 2'd3
    } ohx_mode_e;

    typedef struct packed {
        logic       wide;     // slot is a full byte (G.832)
        logic       first;    // slot index zero
        logic [7:0] payload;
    } ohx_entry_t;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_LOW  = 2'd1,
        SER_HIGH = 2'd2
    } ser_state_e;

endpackage

// File: rtl/ohx_fifo.sv
module ohx_fifo #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;
    logic             accept, take;

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CW'(DEPTH));
    assign take   = pop && !empty;
    assign accept = push && (!full || take);
    assign rdata  = mem[rd_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (accept) mem[wr_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (accept) wr_q <= bump(wr_q);
            if (take)   rd_q <= bump(rd_q);
            unique case ({accept, take})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R7: occupancy never exceeds the configured depth
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R7: a write that was turned away leaves the occupancy unchanged
    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/ohx_serializer.sv
module ohx_serializer
    import ohx_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  ohx_entry_t head,
    output logic       pop,
    output logic       ser_clk,
    output logic       ser_dat,
    output logic       ser_sof
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    ser_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [3:0]  bits_q;
    logic [6:0]  sh_q;
    logic        dat_q, sof_q;
    logic        half_done, last_bit, shift;

    assign half_done = (cnt_q == CW'(HALF_CYC - 1));
    assign last_bit  = (bits_q == 4'd1);

    // next-state and pop decision
    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        shift   = 1'b0;
        unique case (state_q)
            SER_IDLE: begin
                if (!fifo_empty) begin          // start
                    pop     = 1'b1;
                    state_d = SER_LOW;
                end
            end
            SER_LOW: begin
                if (half_done) state_d = SER_HIGH;   // rise
            end
            SER_HIGH: begin
                if (half_done) begin
                    if (!last_bit) begin        // next_bit
                        shift   = 1'b1;
                        state_d = SER_LOW;
                    end else if (!fifo_empty) begin   // next_slot
                        pop     = 1'b1;
                        state_d = SER_LOW;
                    end else begin              // drain
                        state_d = SER_IDLE;
                    end
                end
            end
            default: state_d = SER_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SER_IDLE;
        else        state_q <= state_d;
    end

    // half-period counter and bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bits_q <= '0;
            sh_q   <= '0;
            dat_q  <= 1'b0;
            sof_q  <= 1'b0;
        end else begin
            if (state_d != state_q || state_q == SER_IDLE) cnt_q <= '0;
            else                                             cnt_q <= cnt_q + 1'b1;

            if (pop) begin
                dat_q  <= head.wide ? head.payload[7] : head.payload[0];
                sh_q   <= head.payload[6:0];
                bits_q <= head.wide ? 4'd8 : 4'd1;
                sof_q  <= head.first;
            end else if (shift) begin
                dat_q  <= sh_q[6];
                sh_q   <= {sh_q[5:0], 1'b0};
                bits_q <= bits_q - 1'b1;
                sof_q  <= 1'b0;
            end else if (state_d == SER_IDLE) begin
                sof_q  <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        ser_clk = (state_q == SER_HIGH);
        ser_dat = dat_q;
        ser_sof = sof_q;
    end

    // R2: data presented to the sampler does not move while the clock is high
    p_data_stable_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SER_HIGH) |-> $stable(dat_q));

    // R6: a popped entry always begins with a low half period
    p_pop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (state_q == SER_LOW));

    // R3: a busy serializer always has between one and eight bits left
    p_bits_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SER_IDLE) |-> (bits_q >= 4'd1 && bits_q <= 4'd8));

    // R4: the marker is never shown after the first bit of a slot
    p_sof_first_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> !sof_q);

endmodule

// File: rtl/ohx_port.sv
module ohx_port
    import ohx_pkg::*;
#(
    parameter int IDX_W    = 6,
    parameter int DEPTH    = 4,
    parameter int HALF_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fr_mode,
    input  logic             fr_lof,
    input  logic             fr_oh_stb,
    input  logic [IDX_W-1:0] fr_oh_idx,
    input  logic [7:0]       fr_oh_data,
    input  logic             cfg_inv_clk,
    input  logic             cfg_inv_dat,
    input  logic             cfg_inv_sof,
    output logic             oh_clk,
    output logic             oh_dat,
    output logic             oh_sof,
    output logic             oh_ovf
);
    localparam int EW = $bits(ohx_entry_t);

    ohx_mode_e  mode;
    ohx_entry_t in_ent, head;
    logic       push, pop, empty, full;
    logic       lof_q, ovf_q;
    logic       s_clk, s_dat, s_sof;

    assign mode           = ohx_mode_e'(fr_mode);
    assign push           = fr_oh_stb && !fr_lof;
    assign in_ent.wide    = (mode == MODE_E3_G832);
    assign in_ent.first   = (fr_oh_idx == '0);
    assign in_ent.payload = fr_oh_data;

    ohx_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (in_ent),
        .pop   (pop),
        .rdata (head),
        .empty (empty),
        .full  (full)
    );

    ohx_serializer #(.HALF_CYC(HALF_CYC)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (empty),
        .head       (head),
        .pop        (pop),
        .ser_clk    (s_clk),
        .ser_dat    (s_dat),
        .ser_sof    (s_sof)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lof_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            lof_q <= fr_lof;
            if (push && full && !pop) ovf_q <= 1'b1;
        end
    end

    always_comb begin
        oh_clk = s_clk ^ cfg_inv_clk;
        oh_dat = (s_dat && !lof_q) ^ cfg_inv_dat;
        oh_sof = (s_sof && !lof_q) ^ cfg_inv_sof;
        oh_ovf = ovf_q;
    end

    // R7: once set, the overflow flag stays set
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R7: a refused write raises the flag on the next edge
    p_drop_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> ovf_q);

    // R8: during loss of frame the data line shows its inactive level
    p_lof_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lof_q |-> (oh_dat == cfg_inv_dat && oh_sof == cfg_inv_sof));

endmodule

// File: tb/sim_ohx_port.sv
`timescale 1ns/1ps
module sim_ohx_port;
    localparam int IDX_W = 6;
    localparam int DEPTH = 4;
    localparam int HALF  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] fr_mode = 2'd0;
    logic fr_lof = 1'b0, fr_oh_stb = 1'b0;
    logic [IDX_W-1:0] fr_oh_idx = '0;
    logic [7:0] fr_oh_data = '0;
    logic inv_clk = 1'b0, inv_dat = 1'b0, inv_sof = 1'b0;
    logic oh_clk, oh_dat, oh_sof, oh_ovf;

    always #2.5 clk = ~clk;   // 200 MHz

    ohx_port #(.IDX_W(IDX_W), .DEPTH(DEPTH), .HALF_CYC(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .fr_mode(fr_mode), .fr_lof(fr_lof),
        .fr_oh_stb(fr_oh_stb), .fr_oh_idx(fr_oh_idx), .fr_oh_data(fr_oh_data),
        .cfg_inv_clk(inv_clk), .cfg_inv_dat(inv_dat), .cfg_inv_sof(inv_sof),
        .oh_clk(oh_clk), .oh_dat(oh_dat), .oh_sof(oh_sof), .oh_ovf(oh_ovf)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // expected serial stream
    bit exp_bit [0:2047];
    bit exp_sof [0:2047];
    int exp_req [0:2047];
    int wr = 0, rd = 0;
    int n_rise = 0, rise_cyc = 0, stb_cyc = 0;
    bit prev_c = 1'b0, last_d = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor: find overhead clock rises and compare against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit c, d, s;
            c = oh_clk ^ inv_clk;
            d = oh_dat ^ inv_dat;
            s = oh_sof ^ inv_sof;
            if (c && !prev_c) begin
                n_rise++;
                rise_cyc = cyc;
                if (rd < wr) begin
                    check(d == exp_bit[rd], $sformatf("R%0d data bit %0d", exp_req[rd], rd), d, exp_bit[rd]);
                    check(s == exp_sof[rd], $sformatf("R4 marker bit %0d", rd), s, exp_sof[rd]);
                    rd++;
                end else begin
                    check(1'b0, "R6 unexpected clock pulse", 1, 0);
                end
            end
            if (c && prev_c && d != last_d)
                check(1'b0, "R2 data moved while clock high", d, last_d);
            if (c) last_d = d;
            prev_c = c;
        end
    end

    task automatic model_push(input int mode, input int idx, input logic [7:0] data, input int req);
        if (mode == 3) begin
            for (int b = 7; b >= 0; b--) begin
                exp_bit[wr] = data[b];
                exp_sof[wr] = (idx == 0) && (b == 7);
                exp_req[wr] = req;
                wr++;
            end
        end else begin
            exp_bit[wr] = data[0];
            exp_sof[wr] = (idx == 0);
            exp_req[wr] = req;
            wr++;
        end
    endtask

    task automatic send(input int idx, input logic [7:0] data, input int req);
        @(negedge clk);
        fr_oh_stb  = 1'b1;
        fr_oh_idx  = IDX_W'(idx);
        fr_oh_data = data;
        @(negedge clk);
        fr_oh_stb = 1'b0;
        stb_cyc = cyc;
        if (!fr_lof) model_push(int'(fr_mode), idx, data, req);
    endtask

    task automatic drain();
        int guard = 0;
        while (rd < wr && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2 * HALF + 3) @(negedge clk);
        check(rd == wr, "R6 stream drained", rd, wr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset levels
        check(oh_clk == 1'b0, "R1 clock at reset", oh_clk, 0);
        check(oh_dat == 1'b0, "R1 data at reset", oh_dat, 0);
        check(oh_sof == 1'b0, "R1 marker at reset", oh_sof, 0);
        check(oh_ovf == 1'b0, "R1 overflow at reset", oh_ovf, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6: latency from strobe to first rising edge
        fr_mode = 2'd2;
        send(0, 8'h01, 2);
        drain();
        check(rise_cyc - stb_cyc == HALF + 1, "R6 first rise latency", rise_cyc - stb_cyc, HALF + 1);
        check(oh_clk == 1'b0, "R6 clock low when idle", oh_clk, 0);

        // R2 / R5: bit modes, two frames of ten slots each
        for (int m = 0; m < 3; m++) begin
            fr_mode = 2'(m);
            for (int f = 0; f < 2; f++) begin
                for (int i = 0; i < 10; i++) begin
                    send(i, 8'((i * 29 + m * 7 + f * 3) ^ 8'hA4), (m == 1) ? 5 : 2);
                    repeat (2 * HALF + 1) @(negedge clk);
                end
            end
            drain();
        end

        // R3: G.832 bytes, most significant bit first
        fr_mode = 2'd3;
        for (int f = 0; f < 2; f++) begin
            for (int i = 0; i < 7; i++) begin
                send(i, 8'((i * 37 + f * 11 + 5) & 8'hFF), 3);
                repeat (16 * HALF + 2) @(negedge clk);
            end
        end
        drain();
        check(oh_ovf == 1'b0, "R7 no overflow with paced strobes", oh_ovf, 0);

        // R7: back-to-back strobes overrun the buffer
        @(negedge clk);
        for (int i = 0; i < DEPTH + 2; i++) begin
            fr_oh_stb  = 1'b1;
            fr_oh_idx  = IDX_W'(i);
            fr_oh_data = 8'(8'h3C + i * 17);
            @(negedge clk);
            if (i < DEPTH + 1) model_push(3, i, 8'(8'h3C + i * 17), 7);
        end
        fr_oh_stb = 1'b0;
        check(oh_ovf == 1'b1, "R7 overflow flagged", oh_ovf, 1);
        drain();
        send(1, 8'h81, 7);
        drain();
        check(oh_ovf == 1'b1, "R7 overflow is sticky", oh_ovf, 1);

        // R8: loss of frame
        fr_mode = 2'd2;
        send(1, 8'h01, 2);
        drain();
        check(oh_dat == 1'b1, "R2 data holds last bit", oh_dat, 1);
        @(negedge clk);
        fr_lof = 1'b1;
        repeat (2) @(negedge clk);
        check(oh_dat == 1'b0, "R8 data forced low", oh_dat, 0);
        check(oh_sof == 1'b0, "R8 marker inactive", oh_sof, 0);
        begin
            int r0;
            r0 = n_rise;
            send(0, 8'h01, 8);
            send(2, 8'h01, 8);
            repeat (30) @(negedge clk);
            check(n_rise == r0, "R8 strobes ignored", n_rise, r0);
        end
        fr_lof = 1'b0;
        repeat (2) @(negedge clk);

        // R9: every inversion combination
        for (int k = 0; k < 8; k++) begin
            inv_clk = k[0];
            inv_dat = k[1];
            inv_sof = k[2];
            repeat (2) @(negedge clk);
            check(oh_clk == inv_clk, $sformatf("R9 idle clock level k=%0d", k), oh_clk, inv_clk);
            check(oh_sof == inv_sof, $sformatf("R9 idle marker level k=%0d", k), oh_sof, inv_sof);
            for (int i = 0; i < 3; i++) begin
                send(i, 8'(k + i), 9);
                repeat (2 * HALF + 1) @(negedge clk);
            end
            drain();
        end
        done = 1'b1;
    end

    initial begin
        int w;
        for (w = 0; w < 150000 && !done; w++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=done", w);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule